// File: doc/BRIEF.md
# UART Hardware Flow Control Unit

This block automates RTS/CTS handshaking for a single UART channel. On the send side, it watches the active-low clear-to-send pin from the far end and decides whether the local transmitter may begin another character. A character that has already started always runs to the end of its stop bit. A new start is refused for as long as the far end holds clear-to-send de-asserted. The block can also latch an interrupt when clear-to-send is withdrawn.

On the receive side, the block compares the receive FIFO fill level with two programmable marks. It drives the active-low request-to-send pin high once the upper mark is reached. It drives the pin low again only after the FIFO has drained to the lower mark, so the pin has hysteresis between the two marks. A separate receive-ready condition is raised when the fill level reaches a trigger value.

Software programs the block through a small write port. It clears the latched clear-to-send event with a status-read strobe. The shift registers, baud generator and FIFOs are outside this block.

Top module: `uart_flowctl`

## Requirements
- R1: After synchronous reset, all of the following hold: `rts_n` is 0, `irq` is 0, `int_stat` is 0, and no character start is granted. The register reset values are: feature register 0, enable register 0, upper mark all ones, lower mark 0, trigger 1.
- R2: While feature register (address 0) bit 7 is 0, a start request is granted whenever the transmitter is idle, whatever the value of `cts_n`.
- R3: Enable register (address 1) bit 7 enables the clear-to-send interrupt. A write to it takes effect only while feature bit 4 is 1. While feature bit 4 is 0, a write leaves bit 7 unchanged, so a later clear-to-send withdrawal sets no status.
- R4: When `cts_n` rises with enable bit 7 set, `int_stat` bit 5 becomes 1 and `irq` becomes 1 on the third rising edge after the change, because the pin passes through two synchronizer flops.
- R5: A character in flight is never cut short. After a granted start, no further start is granted until `tx_stop_done` has been seen, whatever the state of `cts_n`.
- R6: With feature bit 7 set, a pending start request is granted two edges after `cts_n` falls back to 0. A start is refused while the synchronized `cts_n` is 1.
- R7: With feature bit 6 set, `rts_n` goes to 1 one edge after `rx_level` reaches the upper mark (address 2). With feature bit 6 clear, `rts_n` stays 0.
- R8: After de-assertion, `rts_n` stays 1 while `rx_level` is above the lower mark (address 3). It returns to 0 one edge after `rx_level` is at or below the lower mark.
- R9: If the lower mark is at or above the upper mark, the lower mark acts as the upper mark minus one.
- R10: `int_stat` bit 2 is 1, one edge after sampling, exactly when `rx_level` is at or above the trigger value (address 4).
- R11: A one-cycle pulse on `rd_stat` clears `int_stat` bit 5 on the next edge. If a clear-to-send withdrawal sets the bit in the same cycle, the set wins.
- R12: `irq` is the OR of two terms: status bit 5 gated by enable bit 7, and status bit 2 gated by enable bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select: 0 feature, 1 enable, 2 upper mark, 3 lower mark, 4 trigger |
| wr_data | input | 8 | Register write data |
| rd_stat | input | 1 | Status read strobe; clears the clear-to-send event |
| cts_n | input | 1 | Active-low clear-to-send from the far end |
| rts_n | output | 1 | Active-low request-to-send to the far end |
| tx_start_req | input | 1 | Transmitter asks to begin a character |
| tx_start_ok | output | 1 | Start granted in this cycle |
| tx_stop_done | input | 1 | Stop bit of the current character has been shifted out |
| rx_level | input | LVL_W | Receive FIFO fill level |
| int_stat | output | 8 | Interrupt status: bit 5 clear-to-send event, bit 2 receive ready |
| irq | output | 1 | Interrupt request |

## Verification
The clear-to-send withdrawal that sets status bit 5 and the status read that clears it can land on the same clock edge. The bench provokes this by raising `cts_n` and asserting `rd_stat` two cycles later, so that the read strobe is sampled on exactly the edge where the synchronized withdrawal is recognised. The bench judges the result by expecting bit 5 and `irq` to stay 1 after that edge, and by expecting a second, lone read to clear them.

// File: rtl/flowctl_pkg.sv
`timescale 1ns/1ps
package flowctl_pkg;

    localparam int REG_ADDR_W = 3;
    localparam int STAT_W     = 8;

    // bit positions inside the feature, enable and status bytes
    localparam int FEAT_AUTO_CTS = 7;
    localparam int FEAT_AUTO_RTS = 6;
    localparam int FEAT_UNLOCK   = 4;
    localparam int IEN_CTS       = 7;
    localparam int IEN_RXRDY     = 0;
    localparam int ST_CTS        = 5;
    localparam int ST_RXRDY      = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_FEAT   = 3'd0,
        REG_IEN    = 3'd1,
        REG_RTS_HI = 3'd2,
        REG_RTS_LO = 3'd3,
        REG_TRIG   = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic auto_cts;
        logic auto_rts;
        logic unlock;
        logic ie_cts;
        logic ie_rx;
    } ctl_t;

    typedef struct packed {
        logic cts_chg;
        logic rx_rdy;
    } pend_t;

    function automatic logic [STAT_W-1:0] pack_status(pend_t p);
        logic [STAT_W-1:0] s;
        s           = '0;
        s[ST_CTS]   = p.cts_chg;
        s[ST_RXRDY] = p.rx_rdy;
        return s;
    endfunction

endpackage

// File: rtl/flowctl_regs.sv
`timescale 1ns/1ps
module flowctl_regs
    import flowctl_pkg::*;
#(
    parameter int LVL_W = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [7:0]            wr_data,
    output ctl_t                  ctl,
    output logic [LVL_W-1:0]      mark_hi,
    output logic [LVL_W-1:0]      mark_lo,
    output logic [LVL_W-1:0]      trig
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl     <= '0;
            mark_hi <= '1;
            mark_lo <= '0;
            trig    <= LVL_W'(1);
        end else if (wr_en) begin
            case (wr_addr)
                REG_FEAT: begin
                    ctl.auto_cts <= wr_data[FEAT_AUTO_CTS];
                    ctl.auto_rts <= wr_data[FEAT_AUTO_RTS];
                    ctl.unlock   <= wr_data[FEAT_UNLOCK];
                end
                REG_IEN: begin
                    ctl.ie_rx <= wr_data[IEN_RXRDY];
                    if (ctl.unlock)
                        ctl.ie_cts <= wr_data[IEN_CTS];
                end
                REG_RTS_HI: mark_hi <= wr_data[LVL_W-1:0];
                REG_RTS_LO: mark_lo <= wr_data[LVL_W-1:0];
                REG_TRIG:   trig    <= wr_data[LVL_W-1:0];
                default: ;
            endcase
        end
    end

    // R3: the interrupt enable for clear-to-send is locked while unlock is clear
    a_r3_ien_locked: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == REG_IEN && !ctl.unlock) |=> $stable(ctl.ie_cts));

endmodule

// File: rtl/flowctl_txgate.sv
`timescale 1ns/1ps
module flowctl_txgate (
    input  logic clk,
    input  logic rst,
    input  logic cts_n,
    input  logic auto_cts,
    input  logic tx_start_req,
    input  logic tx_stop_done,
    output logic tx_start_ok,
    output logic cts_deassert
);

    logic cts_ff1, cts_sync, cts_prev, busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cts_ff1  <= 1'b1;
            cts_sync <= 1'b1;
            cts_prev <= 1'b1;
        end else begin
            cts_ff1  <= cts_n;
            cts_sync <= cts_ff1;
            cts_prev <= cts_sync;
        end
    end

    assign cts_deassert = cts_sync & ~cts_prev;

    // decision taken in the cycle the transmitter asks; only at a character boundary
    assign tx_start_ok = tx_start_req & ~busy & (~auto_cts | ~cts_sync);

    always_ff @(posedge clk) begin
        if (rst)
            busy <= 1'b0;
        else if (tx_start_ok)
            busy <= 1'b1;
        else if (tx_stop_done)
            busy <= 1'b0;
    end

    // R5: nothing new starts while a character is still in flight
    a_r5_no_restart_in_flight: assert property (@(posedge clk) disable iff (rst)
        (busy && !tx_stop_done) |=> !tx_start_ok);

    // R6: a withdrawn clear-to-send seen by the first flop blocks the next cycle's grant
    a_r6_gate_follows_sync: assert property (@(posedge clk) disable iff (rst)
        (auto_cts && cts_ff1) |=> !(tx_start_ok && auto_cts));

endmodule

// File: rtl/flowctl_rts.sv
`timescale 1ns/1ps
module flowctl_rts #(
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             auto_rts,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] mark_hi,
    input  logic [LVL_W-1:0] mark_lo,
    output logic             rts_n
);

    logic [LVL_W-1:0] lo_eff;
    logic             hold;

    // an inverted band collapses to one entry below the upper mark
    assign lo_eff = (mark_lo >= mark_hi) ? mark_hi - 1'b1 : mark_lo;

    always_ff @(posedge clk) begin
        if (rst)
            hold <= 1'b0;
        else if (level >= mark_hi)
            hold <= 1'b1;
        else if (level <= lo_eff)
            hold <= 1'b0;
    end

    assign rts_n = auto_rts & hold;

    // R7: reaching the upper mark stops the far end
    a_r7_stop_at_high: assert property (@(posedge clk) disable iff (rst)
        (level >= mark_hi) |=> hold);

    // R8: inside the band the previous decision is kept
    a_r8_band_keeps_state: assert property (@(posedge clk) disable iff (rst)
        (level < mark_hi && level > lo_eff) |=> (hold == $past(hold)));

endmodule

// File: rtl/flowctl_irq.sv
`timescale 1ns/1ps
module flowctl_irq
    import flowctl_pkg::*;
#(
    parameter int LVL_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ie_cts,
    input  logic              ie_rx,
    input  logic              cts_deassert,
    input  logic              rd_stat,
    input  logic [LVL_W-1:0]  level,
    input  logic [LVL_W-1:0]  trig,
    output logic [STAT_W-1:0] int_stat,
    output logic              irq
);

    pend_t pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else begin
            if (cts_deassert && ie_cts)
                pend.cts_chg <= 1'b1;
            else if (rd_stat)
                pend.cts_chg <= 1'b0;
            pend.rx_rdy <= (level >= trig);
        end
    end

    assign int_stat = pack_status(pend);
    assign irq      = (pend.cts_chg & ie_cts) | (pend.rx_rdy & ie_rx);

    // R4: an enabled withdrawal is latched
    a_r4_event_latched: assert property (@(posedge clk) disable iff (rst)
        (cts_deassert && ie_cts) |=> int_stat[ST_CTS]);

    // R11: a lone read clears the event
    a_r11_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_stat && !(cts_deassert && ie_cts)) |=> !int_stat[ST_CTS]);

    // R10: receive-ready tracks the trigger
    a_r10_rx_ready: assert property (@(posedge clk) disable iff (rst)
        (level >= trig) |=> int_stat[ST_RXRDY]);

    // R12: with both enables off no request leaves the block
    a_r12_masked: assert property (@(posedge clk) disable iff (rst)
        (!ie_cts && !ie_rx) |-> !irq);

endmodule

// File: rtl/uart_flowctl.sv
`timescale 1ns/1ps
module uart_flowctl
    import flowctl_pkg::*;
#(
    parameter int LVL_W = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [7:0]            wr_data,
    input  logic                  rd_stat,
    input  logic                  cts_n,
    output logic                  rts_n,
    input  logic                  tx_start_req,
    output logic                  tx_start_ok,
    input  logic                  tx_stop_done,
    input  logic [LVL_W-1:0]      rx_level,
    output logic [STAT_W-1:0]     int_stat,
    output logic                  irq
);

    ctl_t             ctl;
    logic [LVL_W-1:0] mark_hi, mark_lo, trig;
    logic             cts_deassert;
    logic             unused_unlock;

    assign unused_unlock = ctl.unlock;

    flowctl_regs #(.LVL_W(LVL_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctl     (ctl),
        .mark_hi (mark_hi),
        .mark_lo (mark_lo),
        .trig    (trig)
    );

    flowctl_txgate u_txgate (
        .clk          (clk),
        .rst          (rst),
        .cts_n        (cts_n),
        .auto_cts     (ctl.auto_cts),
        .tx_start_req (tx_start_req),
        .tx_stop_done (tx_stop_done),
        .tx_start_ok  (tx_start_ok),
        .cts_deassert (cts_deassert)
    );

    flowctl_rts #(.LVL_W(LVL_W)) u_rts (
        .clk      (clk),
        .rst      (rst),
        .auto_rts (ctl.auto_rts),
        .level    (rx_level),
        .mark_hi  (mark_hi),
        .mark_lo  (mark_lo),
        .rts_n    (rts_n)
    );

    flowctl_irq #(.LVL_W(LVL_W)) u_irq (
        .clk          (clk),
        .rst          (rst),
        .ie_cts       (ctl.ie_cts),
        .ie_rx        (ctl.ie_rx),
        .cts_deassert (cts_deassert),
        .rd_stat      (rd_stat),
        .level        (rx_level),
        .trig         (trig),
        .int_stat     (int_stat),
        .irq          (irq)
    );

endmodule

// File: tb/test_uart_flowctl.sv
`timescale 1ns/1ps
module test_uart_flowctl;

    localparam int LVL_W = 6;
    localparam int K_RTS = 0, K_IRQ = 1, K_STAT = 2, K_OK = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [2:0]       wr_addr = '0;
    logic [7:0]       wr_data = '0;
    logic             rd_stat = 1'b0;
    logic             cts_n = 1'b0;
    logic             rts_n;
    logic             tx_start_req = 1'b0;
    logic             tx_start_ok;
    logic             tx_stop_done = 1'b0;
    logic [LVL_W-1:0] rx_level = '0;
    logic [7:0]       int_stat;
    logic             irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        int          due;
        int          kind;
        logic [7:0]  val;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;   // 250 MHz

    always @(posedge clk) cyc <= cyc + 1;

    uart_flowctl #(.LVL_W(LVL_W)) i_uart_flowctl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_stat(rd_stat), .cts_n(cts_n), .rts_n(rts_n),
        .tx_start_req(tx_start_req), .tx_start_ok(tx_start_ok), .tx_stop_done(tx_stop_done),
        .rx_level(rx_level), .int_stat(int_stat), .irq(irq)
    );

    function automatic logic [7:0] observe(int kind);
        case (kind)
            K_RTS:   return {7'd0, rts_n};
            K_IRQ:   return {7'd0, irq};
            K_STAT:  return int_stat;
            default: return {7'd0, tx_start_ok};
        endcase
    endfunction

    // monitor: compares every expectation that falls due in this cycle
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due == cyc) begin
                checks++;
                if (observe(sb[i].kind) !== sb[i].val) begin
                    errors++;
                    $display("FAIL %s: actual %0h expected %0h (cycle %0d)",
                             sb[i].tag, observe(sb[i].kind), sb[i].val, cyc);
                end
                sb.delete(i);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic tick_n(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic expect_v(int d, int kind, logic [7:0] v, string tag);
        exp_t e;
        e.due = cyc + d; e.kind = kind; e.val = v; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic stop_pulse();
        tx_stop_done = 1'b1;
        tick();
        tx_stop_done = 1'b0;
    endtask

    task automatic read_pulse();
        rd_stat = 1'b1;
        tick();
        rd_stat = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        tick_n(3);
        rst = 1'b0;
        // R1 reset state
        expect_v(1, K_RTS, 8'h00, "R1 rts_n after reset");
        expect_v(1, K_IRQ, 8'h00, "R1 irq after reset");
        expect_v(1, K_STAT, 8'h00, "R1 int_stat after reset");
        expect_v(1, K_OK, 8'h00, "R1 no grant after reset");
        tick_n(3);

        // R2: auto gating off, cts_n withdrawn does not matter
        cts_n = 1'b1;
        tick_n(4);
        tx_start_req = 1'b1;
        expect_v(0, K_OK, 8'h01, "R2 grant with gating off");
        tick();
        expect_v(0, K_OK, 8'h00, "R5 no grant while busy");
        tx_start_req = 1'b0;
        stop_pulse();

        // R3: enable bit 7 locked while unlock clear
        wr(3'd1, 8'h81);
        cts_n = 1'b0;
        tick_n(4);
        cts_n = 1'b1;
        expect_v(3, K_STAT, 8'h00, "R3 locked enable sets no status");
        expect_v(4, K_IRQ, 8'h00, "R3 locked enable raises no irq");
        tick_n(5);

        // R6: gating on, resume after cts_n returns low
        wr(3'd0, 8'h90);
        wr(3'd1, 8'h80);
        tx_start_req = 1'b1;
        expect_v(0, K_OK, 8'h00, "R6 refused while cts_n high");
        tick();
        cts_n = 1'b0;
        expect_v(1, K_OK, 8'h00, "R6 still refused one edge later");
        expect_v(2, K_OK, 8'h01, "R6 granted two edges after cts_n low");
        tick_n(3);
        tx_start_req = 1'b0;
        tick();
        stop_pulse();

        // R4: withdrawal sets status bit 5 on third edge
        cts_n = 1'b1;
        expect_v(2, K_STAT, 8'h00, "R4 not yet set after two edges");
        expect_v(3, K_STAT, 8'h20, "R4 status bit 5 set");
        expect_v(3, K_IRQ, 8'h01, "R4 irq raised");
        tick_n(4);

        // R11: read clears
        rd_stat = 1'b1;
        expect_v(1, K_STAT, 8'h00, "R11 read clears bit 5");
        expect_v(1, K_IRQ, 8'h00, "R11 irq drops after read");
        tick();
        rd_stat = 1'b0;

        // R5: withdrawal during a character; no new start until resumed
        cts_n = 1'b0;
        tick_n(3);
        tx_start_req = 1'b1;
        expect_v(0, K_OK, 8'h01, "R5 grant before withdrawal");
        tick();
        tx_start_req = 1'b0;
        cts_n = 1'b1;
        tick_n(4);
        stop_pulse();
        tx_start_req = 1'b1;
        expect_v(0, K_OK, 8'h00, "R5 no start after stop bit while withdrawn");
        tick();
        cts_n = 1'b0;
        expect_v(2, K_OK, 8'h01, "R6 start resumes");
        tick_n(3);
        tx_start_req = 1'b0;
        stop_pulse();
        rd_stat = 1'b1;
        expect_v(1, K_STAT, 8'h00, "R11 clear after mid-character event");
        tick();
        rd_stat = 1'b0;

        // R11: set and read on the same edge, set wins
        tick_n(2);
        cts_n = 1'b1;
        tick_n(2);
        rd_stat = 1'b1;
        expect_v(1, K_STAT, 8'h20, "R11 set wins over same-cycle read");
        expect_v(1, K_IRQ, 8'h01, "R11 irq stays after collision");
        tick();
        rd_stat = 1'b0;
        rd_stat = 1'b1;
        expect_v(1, K_STAT, 8'h00, "R11 lone read clears after collision");
        tick();
        rd_stat = 1'b0;
        cts_n = 1'b0;
        tick_n(3);

        // R10 / R12: receive ready
        wr(3'd4, 8'd4);
        wr(3'd1, 8'h81);
        rx_level = 6'd4;
        expect_v(1, K_STAT, 8'h04, "R10 ready at trigger");
        expect_v(1, K_IRQ, 8'h01, "R12 irq from receive ready");
        tick_n(2);
        rx_level = 6'd3;
        expect_v(1, K_STAT, 8'h00, "R10 clear below trigger");
        tick_n(2);
        rx_level = 6'd4;
        tick_n(2);
        wr(3'd1, 8'h80);
        expect_v(0, K_IRQ, 8'h00, "R12 masked receive ready");
        expect_v(0, K_STAT, 8'h04, "R12 status kept while masked");
        tick();

        // R7 / R8: hysteresis
        wr(3'd2, 8'd10);
        wr(3'd3, 8'd4);
        wr(3'd0, 8'hD0);
        rx_level = 6'd9;
        expect_v(1, K_RTS, 8'h00, "R7 below upper mark");
        tick_n(2);
        rx_level = 6'd10;
        expect_v(1, K_RTS, 8'h01, "R7 de-assert at upper mark");
        tick_n(2);
        rx_level = 6'd5;
        expect_v(1, K_RTS, 8'h01, "R8 held inside band");
        tick_n(2);
        rx_level = 6'd4;
        expect_v(1, K_RTS, 8'h00, "R8 re-assert at lower mark");
        tick_n(2);

        // R7: auto request-to-send disabled
        wr(3'd0, 8'h90);
        rx_level = 6'd12;
        expect_v(1, K_RTS, 8'h00, "R7 disabled keeps rts_n low");
        tick_n(2);
        wr(3'd0, 8'hD0);
        expect_v(0, K_RTS, 8'h01, "R7 enabled with level above mark");
        tick();

        // R9: inverted band clamps to upper mark minus one
        wr(3'd3, 8'd12);
        rx_level = 6'd11;
        expect_v(1, K_RTS, 8'h01, "R9 clamped band holds at 11");
        tick_n(2);
        rx_level = 6'd10;
        expect_v(1, K_RTS, 8'h01, "R9 holds at upper mark");
        tick_n(2);
        rx_level = 6'd9;
        expect_v(1, K_RTS, 8'h00, "R9 re-assert one below upper mark");
        tick_n(6);

        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R1 scoreboard: actual %0d pending expected 0", sb.size());
        end
        summary();
        $finish;
    end

endmodule